// File: doc/BRIEF.md
# PWM Timebase with Direction-Qualified Compare Events

This block is the timing core of a pulse-width modulator. A 16-bit counter runs against a programmable period limit (the load value). It runs in one of two shapes. The first is a sawtooth that counts down from the limit to zero and reloads. The second is a triangle that climbs from zero to the limit and falls back to zero. Each cycle the block reports the counter value, a direction flag, and one-cycle event pulses when the counter sits at zero and when it sits at the limit.

Two compare units watch the counter and raise a one-cycle pulse when it equals their programmed value. Each compare unit has separate outputs for a match while rising and a match while falling. Downstream waveform logic can then set a pin on one and clear it on the other, which gives center-aligned PWM. The limit and the counting shape are taken in only at the start of a period, when the counter is at zero, so a period in progress is never cut short. The compare values act immediately.

Top module: `pwm_tbase`

## Requirements
- R1: While reset is asserted and for the two clock edges after its release, `cnt` is 0 and `zero_evt`, `top_evt`, `cmp_up` and `cmp_dn` are all 0.
- R2: In a cycle with `run` low the counter keeps its value at the next edge, and no event output is high in that cycle.
- R3: With `updown` = 0 (sawtooth), each enabled cycle moves the counter one step down, and from 0 it moves to the limit, giving the sequence L, L-1, ..., 1, 0, L.
- R4: With `updown` = 1 (triangle), each enabled cycle moves the counter one step: up from 0 until it reaches L, then down until it reaches 0, giving a period of 2L enabled cycles.
- R5: `dir` is 1 when the next enabled step goes up (triangle mode, counter below L, including at 0) and is 0 otherwise. In sawtooth mode it is always 0.
- R6: `zero_evt` is high exactly in enabled cycles in which the counter is 0.
- R7: `top_evt` is high exactly in enabled cycles in which the counter equals the active limit. In sawtooth mode it therefore follows `zero_evt` on the next enabled cycle.
- R8: In sawtooth mode a compare unit k whose value equals the counter in an enabled cycle pulses `cmp_dn[k]` only, and `cmp_up[k]` stays 0.
- R9: In triangle mode a compare match pulses `cmp_up[k]` when `dir` is 1 and `cmp_dn[k]` when `dir` is 0. A value strictly between 0 and L therefore fires once up and once down per period.
- R10: A compare unit whose value exceeds the active limit raises neither of its outputs.
- R11: `limit` and `updown` are taken in only in an enabled cycle in which the counter is 0. A change at any other time does not alter the counter sequence until the counter next reaches 0.
- R12: With a limit of 0 the counter stays at 0, and `zero_evt` and `top_evt` are both high in every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| run | input | 1 | Count enable; the counter steps only at edges where this is high |
| updown | input | 1 | Counting shape: 0 = sawtooth down, 1 = triangle up/down |
| limit | input | 16 | Period limit (load value), taken in at zero |
| cmp_val | input | 2x16 | Compare values, unit 0 in the low 16 bits |
| cnt | output | 16 | Current counter value |
| dir | output | 1 | 1 while the counter is rising |
| zero_evt | output | 1 | Counter at zero in an enabled cycle |
| top_evt | output | 1 | Counter at the limit in an enabled cycle |
| cmp_up | output | 2 | Per-unit match pulse while rising |
| cmp_dn | output | 2 | Per-unit match pulse while falling or in sawtooth mode |

## Verification
The event outputs and `dir` are decoded from the current counter state with no extra register. They are due in the same cycle the counter holds the value. The counter itself moves one rising edge after an enabled cycle, and a new limit or shape first shows in the cycle where the counter is at zero. The bench drives inputs at the falling edge and compares all outputs 1 ns later against a reference model. It then advances the model once per rising edge, so every comparison sees exactly the state that follows the previous edge. Reset release is given its two synchronizer edges before counting starts.

// File: rtl/pwm_tbase_pkg.sv
`timescale 1ns/1ps
package pwm_tbase_pkg;

  // Counting shape of the timebase.
  typedef enum logic {
    SHAPE_SAW = 1'b0,   // down from limit to zero, then reload
    SHAPE_TRI = 1'b1    // zero up to limit, then back down
  } shape_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/pwm_tbase_shadow.sv
`timescale 1ns/1ps
// Holds the limit and shape in force for the running period. New values are
// taken in only on an enabled cycle at counter zero; in that cycle the
// incoming values are already the effective ones.
module pwm_tbase_shadow
  import pwm_tbase_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         at_zero,
  input  logic [W-1:0] limit_in,
  input  logic         updown_in,
  output logic [W-1:0] eff_limit,
  output logic         eff_tri
);

  logic [W-1:0] limit_q, limit_d;
  shape_e       shape_q, shape_d;
  shape_e       shape_in;
  logic         take;

  assign shape_in = shape_e'(updown_in);
  assign take     = run & at_zero;

  always_comb begin
    limit_d = limit_q;
    shape_d = shape_q;
    if (take) begin
      limit_d = limit_in;
      shape_d = shape_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limit_q <= '0;
      shape_q <= SHAPE_SAW;
    end else if (take) begin
      limit_q <= limit_d;
      shape_q <= shape_d;
    end
  end

  assign eff_limit = at_zero ? limit_in : limit_q;
  assign eff_tri   = at_zero ? (shape_in == SHAPE_TRI) : (shape_q == SHAPE_TRI);

endmodule

// File: rtl/pwm_tbase_ctr.sv
`timescale 1ns/1ps
// Period counter with direction tracking.
module pwm_tbase_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] eff_limit,
  input  logic         eff_tri,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output logic         at_zero,
  output logic         at_top
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         rose_q, rose_d;   // last step taken was upward

  assign at_zero = (cnt_q == '0);
  assign at_top  = (cnt_q == eff_limit);
  assign dir_up  = eff_tri & ~at_top & (at_zero | rose_q);

  always_comb begin
    cnt_d  = cnt_q;
    rose_d = rose_q;
    if (eff_tri) begin
      if (dir_up) begin
        cnt_d  = cnt_q + ONE;
        rose_d = 1'b1;
      end else begin
        rose_d = 1'b0;
        if (!at_zero) begin
          cnt_d = cnt_q - ONE;
        end
      end
    end else begin
      rose_d = 1'b0;
      if (at_zero) begin
        cnt_d = eff_limit;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rose_q <= 1'b0;
    end else if (run) begin
      cnt_q  <= cnt_d;
      rose_q <= rose_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwm_tbase_cmp.sv
`timescale 1ns/1ps
// One compare unit, split by count direction.
module pwm_tbase_cmp #(
  parameter int unsigned W = 16
) (
  input  logic         active,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] eff_limit,
  input  logic         dir_up,
  output logic         hit_up,
  output logic         hit_dn
);

  logic in_range;
  logic hit;

  assign in_range = (cmp <= eff_limit);
  assign hit      = active & in_range & (cnt == cmp);
  assign hit_up   = hit &  dir_up;
  assign hit_dn   = hit & ~dir_up;

endmodule

// File: rtl/pwm_tbase.sv
`timescale 1ns/1ps
module pwm_tbase
  import pwm_tbase_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned NCMP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     updown,
  input  logic [W-1:0]             limit,
  input  logic [NCMP-1:0][W-1:0]   cmp_val,
  output logic [W-1:0]             cnt,
  output logic                     dir,
  output logic                     zero_evt,
  output logic                     top_evt,
  output logic [NCMP-1:0]          cmp_up,
  output logic [NCMP-1:0]          cmp_dn
);

  // Reset: asserted asynchronously, released on the clock.
  logic [RST_SYNC_STAGES-1:0] rsync_q;
  logic                       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[RST_SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_ok = rsync_q[RST_SYNC_STAGES-1];

  logic         act;
  logic [W-1:0] eff_limit;
  logic         eff_tri;
  logic         at_zero;
  logic         at_top;
  logic         dir_up;
  logic [W-1:0] cnt_w;

  assign act = run & rst_ok;

  pwm_tbase_shadow #(.W(W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_ok),
    .run       (run),
    .at_zero   (at_zero),
    .limit_in  (limit),
    .updown_in (updown),
    .eff_limit (eff_limit),
    .eff_tri   (eff_tri)
  );

  pwm_tbase_ctr #(.W(W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_ok),
    .run       (run),
    .eff_limit (eff_limit),
    .eff_tri   (eff_tri),
    .cnt       (cnt_w),
    .dir_up    (dir_up),
    .at_zero   (at_zero),
    .at_top    (at_top)
  );

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    pwm_tbase_cmp #(.W(W)) u_cmp (
      .active    (act),
      .cnt       (cnt_w),
      .cmp       (cmp_val[k]),
      .eff_limit (eff_limit),
      .dir_up    (dir_up),
      .hit_up    (cmp_up[k]),
      .hit_dn    (cmp_dn[k])
    );
  end

  assign cnt      = cnt_w;
  assign dir      = dir_up;
  assign zero_evt = act & at_zero;
  assign top_evt  = act & at_top;

endmodule

// File: rtl/pwm_tbase_chk.sv
`timescale 1ns/1ps
module pwm_tbase_chk #(
  parameter int unsigned W    = 16,
  parameter int unsigned NCMP = 2
) (
  input logic                   clk,
  input logic                   rst_ok,
  input logic                   run,
  input logic [W-1:0]           cnt,
  input logic                   dir,
  input logic                   zero_evt,
  input logic [W-1:0]           eff_limit,
  input logic                   eff_tri,
  input logic [NCMP-1:0][W-1:0] cmp_val,
  input logic [NCMP-1:0]        cmp_up,
  input logic [NCMP-1:0]        cmp_dn
);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_ok)
    !run |=> $stable(cnt));

  a_r3_saw_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (run && !eff_tri && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

  a_r4_tri_rise: assert property (@(posedge clk) disable iff (!rst_ok)
    (run && eff_tri && dir) |=> (cnt == $past(cnt) + W'(1)));

  a_r7_reload_after_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    (zero_evt && !eff_tri) |=> (cnt == $past(eff_limit)));

  a_r11_within_limit: assert property (@(posedge clk) disable iff (!rst_ok)
    cnt <= eff_limit);

  for (genvar k = 0; k < NCMP; k++) begin : g_chk
    a_r10_out_of_range: assert property (@(posedge clk) disable iff (!rst_ok)
      (cmp_val[k] > eff_limit) |-> !(cmp_up[k] || cmp_dn[k]));
  end

endmodule

bind pwm_tbase pwm_tbase_chk #(.W(W), .NCMP(NCMP)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .run       (run),
  .cnt       (cnt),
  .dir       (dir),
  .zero_evt  (zero_evt),
  .eff_limit (eff_limit),
  .eff_tri   (eff_tri),
  .cmp_val   (cmp_val),
  .cmp_up    (cmp_up),
  .cmp_dn    (cmp_dn)
);

// File: tb/pwm_tbase_test.sv
`timescale 1ns/1ps
module pwm_tbase_test;

  localparam int W = 16;
  localparam int NCMP = 2;

  logic                   clk;
  logic                   rst_n;
  logic                   run;
  logic                   updown;
  logic [W-1:0]           limit;
  logic [NCMP-1:0][W-1:0] cmp_val;
  logic [W-1:0]           cnt;
  logic                   dir;
  logic                   zero_evt;
  logic                   top_evt;
  logic [NCMP-1:0]        cmp_up;
  logic [NCMP-1:0]        cmp_dn;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cnt_tag = "";

  // reference model state
  int m_cnt, m_lim;
  bit m_tri, m_rose;

  pwm_tbase #(.W(W), .NCMP(NCMP)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .updown(updown), .limit(limit),
    .cmp_val(cmp_val), .cnt(cnt), .dir(dir), .zero_evt(zero_evt),
    .top_evt(top_evt), .cmp_up(cmp_up), .cmp_dn(cmp_dn)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int eff_lim();
    return (m_cnt == 0) ? int'(limit) : m_lim;
  endfunction

  function automatic bit eff_tri();
    return (m_cnt == 0) ? updown : m_tri;
  endfunction

  function automatic bit exp_dir();
    return eff_tri() && (m_cnt != eff_lim()) && (m_cnt == 0 || m_rose);
  endfunction

  // Called just after a falling edge with inputs set: compare, then advance model.
  task automatic cycle();
    int  l;
    bit  t, d, hit;
    string tg;
    #1;
    l = eff_lim();
    t = eff_tri();
    d = exp_dir();
    if (cnt_tag != "") tg = cnt_tag;
    else if (!run) tg = "R2";
    else if (l == 0) tg = "R12";
    else tg = t ? "R4" : "R3";
    chk(tg, "cnt", int'(cnt), m_cnt);
    chk("R5", "dir", int'(dir), int'(d));
    chk(run ? "R6" : "R2", "zero_evt", int'(zero_evt), int'(run && m_cnt == 0));
    chk(run ? "R7" : "R2", "top_evt", int'(top_evt), int'(run && m_cnt == l));
    for (int k = 0; k < NCMP; k++) begin
      hit = run && int'(cmp_val[k]) <= l && m_cnt == int'(cmp_val[k]);
      if (!run) tg = "R2";
      else if (int'(cmp_val[k]) > l) tg = "R10";
      else tg = t ? "R9" : "R8";
      chk(tg, $sformatf("cmp_up[%0d]", k), int'(cmp_up[k]), int'(hit && d));
      chk(tg, $sformatf("cmp_dn[%0d]", k), int'(cmp_dn[k]), int'(hit && !d));
    end
    if (run) begin
      if (m_cnt == 0) begin
        m_lim = int'(limit);
        m_tri = updown;
      end
      if (t) begin
        if (d) begin m_cnt = m_cnt + 1; m_rose = 1; end
        else begin m_rose = 0; if (m_cnt != 0) m_cnt = m_cnt - 1; end
      end else begin
        m_rose = 0;
        m_cnt = (m_cnt == 0) ? l : m_cnt - 1;
      end
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(bit ud, int l, int ca, int cb);
    updown = ud;
    limit = W'(l);
    cmp_val[0] = W'(ca);
    cmp_val[1] = W'(cb);
  endtask

  initial begin
    void'($urandom(32'd24681));
    rst_n = 1'b0;
    run = 1'b0;
    set_cfg(0, 5, 3, 9);
    m_cnt = 0; m_lim = 0; m_tri = 0; m_rose = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    chk("R1", "cnt in reset", int'(cnt), 0);
    chk("R1", "events in reset", int'({zero_evt, top_evt, cmp_up, cmp_dn}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "cnt after release", int'(cnt), 0);
    @(negedge clk);

    // R2: idle holds
    run = 1'b0;
    repeat (4) cycle();

    // R3/R8/R10: sawtooth, limit 5, compare 3 and 9 (beyond limit)
    run = 1'b1;
    repeat (20) cycle();

    // R11: change limit and shape mid-period; sequence unaffected until zero
    while (m_cnt != 3) cycle();
    set_cfg(1, 7, 7, 0);
    cnt_tag = "R11";
    repeat (3) cycle();
    cnt_tag = "";
    repeat (30) cycle();

    // R4/R9: triangle, interior compares
    set_cfg(1, 6, 2, 5);
    repeat (40) cycle();

    // R2 inside a running period
    run = 1'b0;
    repeat (3) cycle();
    run = 1'b1;
    repeat (5) cycle();

    // R12: limit zero in both shapes
    set_cfg(1, 0, 0, 1);
    repeat (20) cycle();
    set_cfg(0, 0, 0, 1);
    repeat (10) cycle();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(39) == 0) begin
        updown = 1'($urandom_range(1));
        limit = W'($urandom_range(20));
      end
      if ($urandom_range(29) == 0) begin
        cmp_val[0] = W'($urandom_range(24));
        cmp_val[1] = W'($urandom_range(24));
      end
      run = ($urandom_range(7) != 0);
      cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule